// File: doc/BRIEF.md
# Flash Write-Cycle Qualification Guard

This block sits at the device-side front of a parallel NOR-style flash, ahead of the command sequence decoder. It watches the three active-low bus strobes (chip enable, output enable and write enable) and a supply-lockout flag from an external comparator. All four inputs are sampled in a fast system clock. The block decides whether a bus cycle is a real write to the command register. When a cycle qualifies, the block issues a one-clock write strobe together with the address and data captured on that cycle.

Three defences feed a single accept decision:
- **Glitch rejection.** A strobe low period shorter than a parameterised number of clocks is discarded.
- **Logical inhibit.** Output enable low or chip enable high during the cycle vetoes the write.
- **Supply lockout.** While the lockout flag is raised, no write is accepted.

Each time the lockout flag rises, the block also sends the decoder a single reset-to-read pulse. The decoder then drops any partial command sequence, so a stray cycle around a supply transition cannot complete a program or erase command.

Top module: `norWriteGuard`

## Requirements
- R1: Out of reset, `wrPulse` and `readReset` are 0, and `wrAddr` and `wrData` are 0.
- R2: A bus cycle in which `ceN` and `weN` are both low for at least GLITCH_CYCLES consecutive clocks, with `oeN` high and `lowSupply` low throughout, produces exactly one `wrPulse`. The pulse comes within SYNC_STAGES+3 clocks of the strobes returning high. It carries the `addrIn`/`dataIn` values present during the cycle's final low clock.
- R3: `wrPulse` lasts one clock, and one low period of the strobes yields at most one pulse, however long it lasts.
- R4: A low period lasting GLITCH_CYCLES-1 clocks produces no `wrPulse`; one lasting exactly GLITCH_CYCLES clocks produces one.
- R5: If `oeN` is low on any clock of the low period, the cycle produces no `wrPulse`.
- R6: With `ceN` held high, a low pulse on `weN` alone produces no `wrPulse`. Likewise, `ceN` low with `weN` high produces none.
- R7: While `lowSupply` is 1, no cycle produces a `wrPulse`. This includes a cycle during which `lowSupply` rises part-way through.
- R8: Each 0-to-1 transition of `lowSupply` produces exactly one single-clock `readReset` pulse; a 1-to-0 transition produces none.
- R9: After `lowSupply` returns to 0, a qualifying cycle is again accepted as in R2.
- R10: `wrAddr` and `wrData` change only together with a `wrPulse`, and hold their value between pulses whatever `addrIn`/`dataIn` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip enable strobe, active low, asynchronous |
| oeN | input | 1 | Output enable strobe, active low, asynchronous |
| weN | input | 1 | Write enable strobe, active low, asynchronous |
| addrIn | input | ADDR_W | Bus address |
| dataIn | input | DATA_W | Bus write data |
| lowSupply | input | 1 | Supply-below-threshold flag from the comparator |
| wrPulse | output | 1 | One-clock accepted-write strobe |
| wrAddr | output | ADDR_W | Address of the last accepted write |
| wrData | output | DATA_W | Data of the last accepted write |
| readReset | output | 1 | One-clock request to return the decoder to read mode |

## Verification
**Glitch boundary.** The bench probes the width filter with low periods of GLITCH_CYCLES-1 and exactly GLITCH_CYCLES clocks. An off-by-one counter would either pass the short glitch or drop the minimum legal write.

**Inhibit terms.** It dips output enable for a single clock in the middle of an otherwise valid cycle. A design that sampled the inhibit only at the end of the cycle would accept that write. It also raises the lockout flag part-way through a cycle. A design that folded lockout into the strobe window would treat the lockout edge as the cycle's end and emit a write carrying stale data.

**Long cycles and held data.** A long low period checks against repeated strobes. Changing the bus with no strobe checks that the latched address and data stay put.

// File: rtl/nwgPkg.sv
package nwgPkg;

  // Strobes passed from the qualification control to the datapath.
  typedef struct packed {
    logic capture;  // cycle is inside a clean, uninhibited write window
    logic fire;     // window just closed and qualified as a real write
  } guardCtl_t;

endpackage

// File: rtl/nwgControl.sv
module nwgControl
  import nwgPkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int GLITCH_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      oeN,
  input  logic      weN,
  input  logic      lowSupply,
  output guardCtl_t ctl,
  output logic      readReset
);

  localparam int CNT_W = $clog2(GLITCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(GLITCH_CYCLES);

  // Bit order in each synchronizer stage: {lock, we, oe, ce}.
  logic [3:0] syncChain [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= 4'b1111;
    else       syncChain[0] <= {lowSupply, weN, oeN, ceN};
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[s] <= 4'b1111;
      else       syncChain[s] <= syncChain[s-1];
    end
  end

  logic ceS, oeS, weS, lockS;
  assign {lockS, weS, oeS, ceS} = syncChain[SYNC_STAGES-1];

  logic winLow, blockTerm, winPrev, spoiled, lockPrev;
  logic [CNT_W-1:0] lowCnt;

  assign winLow    = !ceS && !weS;
  assign blockTerm = !oeS || lockS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winPrev <= 1'b0;
      spoiled <= 1'b0;
      lowCnt  <= '0;
    end else begin
      winPrev <= winLow;
      if (!winLow) begin
        spoiled <= 1'b0;
        lowCnt  <= '0;
      end else if (blockTerm) begin
        spoiled <= 1'b1;
      end else if (lowCnt < CNT_MAX) begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  assign ctl.capture = winLow && !blockTerm;
  assign ctl.fire    = winPrev && !winLow && !spoiled && !lockS && (lowCnt >= CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockPrev  <= 1'b1;
      readReset <= 1'b0;
    end else begin
      lockPrev  <= lockS;
      readReset <= lockS && !lockPrev;
    end
  end

  assert_fire_needs_oe_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fire |-> $past(oeS));

  assert_fire_full_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fire |-> (lowCnt == CNT_MAX));

  assert_read_reset_on_lock_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockS) |=> readReset);

  assert_read_reset_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    readReset |=> !readReset);

endmodule

// File: rtl/nwgDatapath.sv
module nwgDatapath
  import nwgPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  guardCtl_t         ctl,
  output logic              wrPulse,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam int PW = ADDR_W + DATA_W;

  // Delay the bus by the synchronizer depth so it lines up with the strobes.
  logic [PW-1:0] busPipe [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busPipe[0] <= '0;
    else       busPipe[0] <= {addrIn, dataIn};
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gAlign
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) busPipe[s] <= '0;
      else       busPipe[s] <= busPipe[s-1];
    end
  end

  logic [PW-1:0] capReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg  <= '0;
      wrPulse <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      if (ctl.capture) capReg <= busPipe[SYNC_STAGES-1];
      wrPulse <= ctl.fire;
      if (ctl.fire) {wrAddr, wrData} <= capReg;
    end
  end

  assert_pulse_one_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |=> !wrPulse);

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wrAddr) |-> wrPulse);

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wrData) |-> wrPulse);

endmodule

// File: rtl/norWriteGuard.sv
module norWriteGuard
  import nwgPkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int GLITCH_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              lowSupply,
  output logic              wrPulse,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              readReset
);

  guardCtl_t ctl;

  nwgControl #(
    .SYNC_STAGES  (SYNC_STAGES),
    .GLITCH_CYCLES(GLITCH_CYCLES)
  ) uControl (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .oeN      (oeN),
    .weN      (weN),
    .lowSupply(lowSupply),
    .ctl      (ctl),
    .readReset(readReset)
  );

  nwgDatapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDatapath (
    .clk    (clk),
    .rstN   (rstN),
    .addrIn (addrIn),
    .dataIn (dataIn),
    .ctl    (ctl),
    .wrPulse(wrPulse),
    .wrAddr (wrAddr),
    .wrData (wrData)
  );

endmodule

// File: tb/tb_norWriteGuard.sv
module tb_norWriteGuard;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int GL = 4;

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1, lowSupply = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic wrPulse, readReset;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;

  int compared = 0;
  int mismatched = 0;
  int rrCount = 0;
  bit prevPulse = 1'b0;
  bit finished = 1'b0;
  string curReq = "R1";
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  norWriteGuard #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .GLITCH_CYCLES(GL)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addrIn(addrIn), .dataIn(dataIn), .lowSupply(lowSupply),
    .wrPulse(wrPulse), .wrAddr(wrAddr), .wrData(wrData), .readReset(readReset)
  );

  // Monitor: pops expected writes and compares against each accepted write.
  always @(negedge clk) begin
    if (rstN) begin
      if (readReset) rrCount++;
      if (wrPulse) begin
        compared++;
        if (prevPulse) begin
          mismatched++;
          $display("FAIL R3: wrPulse high two clocks running, actual 1 expected 0");
        end else if (expQ.size() == 0) begin
          mismatched++;
          $display("FAIL %s: unexpected write addr=%h data=%h, expected none", curReq, wrAddr, wrData);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          if (wrAddr !== e.addr || wrData !== e.data) begin
            mismatched++;
            $display("FAIL %s (R2): write addr=%h data=%h, expected addr=%h data=%h",
                     curReq, wrAddr, wrData, e.addr, e.data);
          end
        end
      end
      prevPulse = wrPulse;
    end
  end

  task automatic checkEq(input int actual, input int expected, input string req);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic drainCheck(input string req);
    repeat (8) @(negedge clk);
    checkEq(expQ.size(), 0, req);
  endtask

  // One bus cycle: strobes held at the given levels for lowLen clocks.
  // oeDip >= 0 pulls output enable low on that clock of the window.
  task automatic busCycle(input logic ceL, input logic weL, input int lowLen,
                          input int oeDip, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input bit expectWr, input string req);
    curReq = req;
    @(negedge clk);
    addrIn = a; dataIn = d;
    if (expectWr) expQ.push_back('{addr: a, data: d});
    ceN = ceL; weN = weL;
    for (int i = 0; i < lowLen; i++) begin
      oeN = (i == oeDip) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    drainCheck(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq(int'(wrPulse), 0, "R1");
    checkEq(int'(readReset), 0, "R1");
    checkEq(int'(wrAddr), 0, "R1");
    checkEq(int'(wrData), 0, "R1");

    // R2 plain writes
    busCycle(1'b0, 1'b0, GL + 3, -1, 16'h0555, 16'h00AA, 1'b1, "R2");
    busCycle(1'b0, 1'b0, GL + 1, -1, 16'h02AA, 16'h0055, 1'b1, "R2");
    // R3 long low period: one pulse only
    busCycle(1'b0, 1'b0, 25, -1, 16'h1234, 16'hBEEF, 1'b1, "R3");
    // R4 glitch boundary
    busCycle(1'b0, 1'b0, GL - 1, -1, 16'h0F0F, 16'h1111, 1'b0, "R4");
    busCycle(1'b0, 1'b0, GL, -1, 16'h0F0E, 16'h2222, 1'b1, "R4");
    // R5 output enable low: whole window, then a one-clock dip
    curReq = "R5";
    @(negedge clk); addrIn = 16'hAAAA; ceN = 1'b0; weN = 1'b0; oeN = 1'b0;
    repeat (GL + 3) @(negedge clk);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    drainCheck("R5");
    busCycle(1'b0, 1'b0, GL + 4, 3, 16'hBBBB, 16'h3333, 1'b0, "R5");
    // R6 chip enable high or write enable high
    busCycle(1'b1, 1'b0, GL + 4, -1, 16'hCCCC, 16'h4444, 1'b0, "R6");
    busCycle(1'b0, 1'b1, GL + 4, -1, 16'hCCCD, 16'h4445, 1'b0, "R6");
    // R10 outputs hold while the bus moves
    @(negedge clk); addrIn = 16'hFFFF; dataIn = 16'hFFFF;
    repeat (5) @(negedge clk);
    checkEq(int'(wrAddr), 16'h0F0E, "R10");
    checkEq(int'(wrData), 16'h2222, "R10");

    // R8 lockout rise gives one readReset
    @(negedge clk); lowSupply = 1'b1;
    repeat (6) @(negedge clk);
    checkEq(rrCount, 1, "R8");
    // R7 writes ignored during lockout
    busCycle(1'b0, 1'b0, GL + 3, -1, 16'h4321, 16'h5555, 1'b0, "R7");
    @(negedge clk); lowSupply = 1'b0;
    repeat (6) @(negedge clk);
    checkEq(rrCount, 1, "R8");
    // R9 accepted again after lockout clears
    busCycle(1'b0, 1'b0, GL + 2, -1, 16'h0777, 16'h6666, 1'b1, "R9");

    // R7 lockout rising in the middle of a window
    curReq = "R7";
    @(negedge clk); addrIn = 16'h0999; dataIn = 16'h7777; ceN = 1'b0; weN = 1'b0;
    repeat (GL + 2) @(negedge clk);
    lowSupply = 1'b1;
    repeat (4) @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    drainCheck("R7");
    checkEq(rrCount, 2, "R8");
    checkEq(int'(wrAddr), 16'h0777, "R10");
    @(negedge clk); lowSupply = 1'b0;
    repeat (6) @(negedge clk);
    busCycle(1'b0, 1'b0, GL + 5, -1, 16'h0ABC, 16'h8888, 1'b1, "R9");
    checkEq(rrCount, 2, "R8");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule